// File: doc/BRIEF.md
# Negative-Flag Relative Branch Unit

This block carries out a conditional relative branch that depends on the negative status flag. A four-phase sequencer input divides each instruction cycle into phases Q1 to Q4. The unit recognises the branch opcode in Q1 and latches the signed 8-bit word offset in Q2. In Q3 it samples the negative flag and the current instruction address, then works out the next program counter. When the branch is taken, a program-counter write strobe is raised for the Q4 phase.

A taken branch costs one extra instruction cycle. During that cycle the unit holds a flush indication so that the surrounding pipeline discards the instruction that was already prefetched. Any instruction presented during that cycle is ignored. The program counter is 21 bits wide and byte-addressed. Its bit 0 is always zero and all target arithmetic wraps modulo 2^21. The unit changes no status flags.

Top module: `bn_branch_unit`

## Requirements
- R1: Only an instruction whose bits 15:8 equal 8'hE6 when sampled in phase Q1 (phase_i = 0) is treated as the branch. Any other opcode yields pc_next_o = pc_i + 2 with pc_wr_o low.
- R2: The offset n is taken from instr_i bits 7:0 as sampled in phase Q2 (phase_i = 1) and read as two's complement (-128 to +127). Values on instr_i during Q3 and Q4 have no effect.
- R3: When the branch is taken, pc_next_o = pc_i + 2 + 2n during Q4 (phase_i = 3). pc_wr_o is high during that Q4 phase and low in every other phase.
- R4: When the negative flag is 0 at Q3, the branch is not taken: pc_next_o = pc_i + 2 during Q4 and pc_wr_o stays low.
- R5: After a taken branch, flush_o is high for all four phases of the next instruction cycle. It is low in every other cycle.
- R6: An instruction presented during a flush cycle is discarded. It produces no write strobe, pc_next_o keeps its value, and no further flush cycle follows.
- R7: pc_next_o bit 0 is always zero, and the target wraps modulo 2^21.
- R8: neg_i and pc_i are sampled in phase Q3 (phase_i = 2).
- R9: While rst_n is low, pc_next_o, pc_wr_o and flush_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 21 | Address of the current instruction |
| neg_i | input | 1 | Negative status flag |
| pc_next_o | output | 21 | Next program counter, valid in Q4 |
| pc_wr_o | output | 1 | Program-counter load strobe, taken branch, Q4 only |
| flush_o | output | 1 | Discard indication for the whole extra cycle |

## Verification
The hardest situation to reach is a branch-opcode word with the negative flag set that arrives during the flush cycle. A naive design would branch on it again and chain flushes. The stimulus reaches this case by issuing a taken branch and then, as the very next instruction cycle, driving another taken-looking branch word. The scoreboard then expects a held pc_next_o, no strobe and no second flush. The stimulus also drives a dummy all-ones word during Q3 and Q4 of every cycle, which shows that only the Q1 and Q2 samples matter.

// File: rtl/bn_pkg.sv
package bn_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam logic [7:0] BN_OPCODE = 8'hE6;
endpackage

// File: rtl/bn_opcode_match.sv
module bn_opcode_match #(
    parameter int INSTR_W = 16,
    parameter int OPC_W   = 8,
    parameter logic [OPC_W-1:0] OPCODE = bn_pkg::BN_OPCODE
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic               hit_o
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    assign hit_o = (instr_i[INSTR_W-1:OPC_LSB] == OPCODE);
endmodule

// File: rtl/bn_target_calc.sv
module bn_target_calc #(
    parameter int PC_W  = 21,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  tgt_o
);
    localparam int WORD_W = PC_W - 1;
    localparam int EXT_W  = WORD_W - OFF_W;

    logic [WORD_W-1:0] word_seq;
    logic [WORD_W-1:0] word_off;

    // Word-granular arithmetic: bit 0 of the byte address is never computed.
    assign word_seq = pc_i[PC_W-1:1] + {{(WORD_W-1){1'b0}}, 1'b1};
    assign word_off = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    assign seq_o    = {word_seq, 1'b0};
    assign tgt_o    = {word_seq + word_off, 1'b0};
endmodule

// File: rtl/bn_branch_unit.sv
module bn_branch_unit #(
    parameter int PC_W    = 21,
    parameter int INSTR_W = 16,
    parameter int OFF_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         phase_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               neg_i,
    output logic [PC_W-1:0]    pc_next_o,
    output logic               pc_wr_o,
    output logic               flush_o
);
    import bn_pkg::*;

    localparam int OPC_W = INSTR_W - OFF_W;

    typedef struct packed {
        logic             flush;
        logic             is_bn;
        logic [OFF_W-1:0] off;
        logic [PC_W-1:0]  pc_next;
        logic             pc_wr;
    } state_t;

    state_t st_d, st_q;
    phase_e phase;
    logic   opc_hit;
    logic   taken;
    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] pc_tgt;

    assign phase = phase_e'(phase_i);

    bn_opcode_match #(
        .INSTR_W (INSTR_W),
        .OPC_W   (OPC_W),
        .OPCODE  (OPC_W'(BN_OPCODE))
    ) u_match (
        .instr_i (instr_i),
        .hit_o   (opc_hit)
    );

    bn_target_calc #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_tgt (
        .pc_i  (pc_i),
        .off_i (st_q.off),
        .seq_o (pc_seq),
        .tgt_o (pc_tgt)
    );

    assign taken = st_q.is_bn && neg_i;

    always_comb begin
        st_d       = st_q;
        st_d.pc_wr = 1'b0;
        unique case (phase)
            PH_Q1: st_d.is_bn = opc_hit && !st_q.flush;
            PH_Q2: st_d.off = instr_i[OFF_W-1:0];
            PH_Q3: begin
                if (!st_q.flush) begin
                    st_d.pc_next = taken ? pc_tgt : pc_seq;
                    st_d.pc_wr   = taken;
                end
            end
            PH_Q4: begin
                st_d.flush = st_q.pc_wr;
                st_d.is_bn = 1'b0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_next_o = st_q.pc_next;
    assign pc_wr_o   = st_q.pc_wr;
    assign flush_o   = st_q.flush;
endmodule

// File: rtl/bn_branch_checker.sv
module bn_branch_checker #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      phase_i,
    input logic [PC_W-1:0] pc_next_o,
    input logic            pc_wr_o,
    input logic            flush_o
);
    // R3: the load strobe appears only in the Q4 phase
    assert_wr_in_q4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_o |-> (phase_i == 2'd3));

    // R5: a taken branch is followed by a flush cycle
    assert_flush_after_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_o |=> flush_o);

    // R5: flush changes only at a cycle boundary
    assert_flush_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != 2'd0) |-> $stable(flush_o));

    // R6: nothing is loaded while a flush cycle runs
    assert_no_wr_in_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !pc_wr_o);

    // R6: the flush cycle does not trigger another one
    assert_no_chained_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && phase_i == 2'd3) |=> !flush_o);

    // R7: the byte address is always word-aligned
    assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_next_o[0] == 1'b0);
endmodule

bind bn_branch_unit bn_branch_checker #(.PC_W(PC_W)) u_bn_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase_i),
    .pc_next_o (pc_next_o),
    .pc_wr_o   (pc_wr_o),
    .flush_o   (flush_o)
);

// File: tb/bn_branch_unit_tb.sv
module bn_branch_unit_tb_top;
    localparam int PC_W = 21;
    localparam logic [PC_W-1:0] MASK = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      phase_i = 2'd0;
    logic [15:0]     instr_i = 16'h0000;
    logic [PC_W-1:0] pc_i = '0;
    logic            neg_i = 1'b0;
    logic [PC_W-1:0] pc_next_o;
    logic            pc_wr_o;
    logic            flush_o;

    typedef struct {
        logic            flush;
        logic            wr;
        logic [PC_W-1:0] pc;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    logic            flush_pend = 1'b0;
    logic [PC_W-1:0] last_pc = '0;

    always #5 clk = ~clk;

    bn_branch_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase_i),
        .instr_i   (instr_i),
        .pc_i      (pc_i),
        .neg_i     (neg_i),
        .pc_next_o (pc_next_o),
        .pc_wr_o   (pc_wr_o),
        .flush_o   (flush_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected outcome, then drives one instruction cycle
    task automatic run_cycle(input logic [15:0] instr, input logic [PC_W-1:0] pc,
                             input logic neg, input string tag);
        exp_t e;
        e.tag = tag;
        if (flush_pend) begin
            e.flush = 1'b1; e.wr = 1'b0; e.pc = last_pc;
            flush_pend = 1'b0;
        end else begin
            logic bn;
            logic taken;
            int   n;
            bn    = (instr[15:8] == 8'hE6);
            taken = bn && neg;
            n     = int'($signed(instr[7:0]));
            e.flush = 1'b0;
            e.wr    = taken;
            e.pc    = taken ? PC_W'(int'(pc) + 2 + 2 * n) & MASK
                            : PC_W'(int'(pc) + 2) & MASK;
            last_pc    = e.pc;
            flush_pend = taken;
        end
        exp_q.push_back(e);
        for (int p = 0; p < 4; p++) begin
            @(posedge clk);
            #1;
            phase_i = 2'(p);
            instr_i = (p < 2) ? instr : 16'hFFFF;   // R2: late word must not matter
            pc_i    = pc;
            neg_i   = neg;
        end
    endtask

    // Monitor: compares every phase against the head of the queue
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            check({exp_q[0].tag, " R5 flush"}, 32'(flush_o), 32'(exp_q[0].flush));
            check({exp_q[0].tag, " R3 strobe"}, 32'(pc_wr_o),
                  32'(exp_q[0].wr && phase_i == 2'd3));
            if (phase_i == 2'd3) begin
                check({exp_q[0].tag, " pc_next"}, 32'(pc_next_o), 32'(exp_q[0].pc));
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset pc_next", 32'(pc_next_o), 32'h0);
        check("R9 reset strobe", 32'(pc_wr_o), 32'h0);
        check("R9 reset flush", 32'(flush_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        run_cycle(16'hE605, 21'h000100, 1'b1, "R3 taken +5");
        run_cycle(16'h1234, 21'h000102, 1'b1, "R5 flush after taken");
        run_cycle(16'hE605, 21'h000200, 1'b0, "R4 not taken");
        run_cycle(16'hE705, 21'h000300, 1'b1, "R1 other opcode");
        run_cycle(16'h0605, 21'h000304, 1'b1, "R1 low-byte opcode bits");
        run_cycle(16'hE67F, 21'h001000, 1'b1, "R2 offset +127");
        run_cycle(16'h0000, 21'h001002, 1'b0, "R5 flush");
        run_cycle(16'hE680, 21'h001000, 1'b1, "R2 offset -128");
        run_cycle(16'hE610, 21'h001002, 1'b1, "R6 branch in flush ignored");
        run_cycle(16'h0000, 21'h001004, 1'b0, "R6 no chained flush");
        run_cycle(16'hE600, 21'h1FFFFE, 1'b1, "R7 wrap high");
        run_cycle(16'h0000, 21'h000000, 1'b0, "R5 flush");
        run_cycle(16'hE680, 21'h000010, 1'b1, "R7 wrap low");
        run_cycle(16'h0000, 21'h000012, 1'b0, "R5 flush");
        run_cycle(16'hE6FF, 21'h000400, 1'b1, "R8 taken -1");
        run_cycle(16'h0000, 21'h000402, 1'b0, "R5 flush");
        run_cycle(16'hE640, 21'h000500, 1'b0, "R8 flag clear");

        @(posedge clk);
        #1;
        phase_i = 2'd0;
        repeat (2) @(negedge clk);
        check("R6 queue drained", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule